// File: doc/BRIEF.md
# I2C Multi-Space Configuration Target

This block is an I2C target that occupies a group of four consecutive 7-bit addresses. Each address in the group selects one of three 256-byte spaces:
- a live configuration RAM;
- a non-volatile image, modelled as a register array that reports when it is busy;
- a user data store.

A four-bit code held in one byte of the configuration RAM sets where the group sits on the bus. A host that rewrites that byte moves the device to a new group without a reset.

Writes carry a pointer byte followed by any number of data bytes. A read first sets the pointer with a write, then sends a repeated START and reads bytes back. After reset the block copies the whole non-volatile image into the configuration RAM. It ignores the bus until that copy is done.

The block oversamples SCL and SDA on its own clock. It pulls SDA low through an open-drain enable and never stretches the clock.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the non-volatile image holds 0x01 at byte 0xCA and zero elsewhere, so the group is 0x08..0x0B and all four addresses acknowledge. The target changes its SDA drive only while SCL is low, and it releases SDA after a STOP.
- R2: A write to base+0 puts the first data byte at the pointer given by the pointer byte, and a later read at that pointer through base+0 returns it.
- R3: Base+1 is an alias of the configuration RAM: it reads and writes the same bytes as base+0.
- R4: Base+2 selects the non-volatile image and base+3 selects the data store. A write to one space leaves the same pointer in the other spaces unchanged.
- R5: The pointer advances by one after every data byte, whether written or read, and wraps from 0xFF to 0x00.
- R6: After reset the block copies all 256 bytes of the image into the configuration RAM and acknowledges nothing until the copy is complete, so RAM byte 0xCA reads 0x01.
- R7: After each data byte written to the image, base+2 is not acknowledged for NVM_WR_CYC clock cycles, while the other addresses in the group still acknowledge. After that time the written value reads back.
- R8: The group base is the low four bits of RAM byte 0xCA shifted left by 3. A new value takes effect at the STOP that ends the transaction which wrote it. The rest of that transaction is still served at the old addresses.
- R9: Addresses outside the four-address group are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When high, the target pulls SDA low |

## Verification
Each bus line passes through a two-stage synchronizer and an edge detector. Because of this, the target's reaction to an SCL edge shows up on sda_oe about three clock cycles later. The ACK for a byte is therefore on the wire a few cycles after the eighth falling edge of SCL.

The bench holds SCL low and high for ten cycles each, and it samples SDA five cycles into each high phase, well clear of that latency. It waits 300 cycles after reset so the 256-cycle power-up copy is finished. For R7 it probes the image address at once after a write, then waits more than NVM_WR_CYC cycles before reading the value back. After the code byte is rewritten, it probes the old and new groups only after the STOP.

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target #(
  parameter int unsigned AW           = 8,
  parameter int unsigned CODE_BYTE    = 8'hCA,
  parameter logic [3:0]  DEFAULT_CODE = 4'd1,
  parameter int unsigned NVM_WR_CYC   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned BW    = $clog2(NVM_WR_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_RX, S_RXACK, S_TX, S_TXACK} st_t;

  logic [7:0]    ram [DEPTH];
  logic [7:0]    nvm [DEPTH];
  logic [7:0]    eep [DEPTH];
  logic [2:0]    scl_r, sda_r;
  st_t           st;
  logic [7:0]    sh, rd_byte;
  logic [3:0]    bitc, code_q;
  logic [1:0]    sp;
  logic [AW-1:0] ptr, copy_idx;
  logic [BW-1:0] busy_cnt;
  logic          rw, is_ptr, ack_m, copy_busy;

  wire scl_s = scl_r[1];
  wire scl_p = scl_r[2];
  wire sda_s = sda_r[1];
  wire sda_p = sda_r[2];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire nvm_busy  = busy_cnt != '0;
  wire hit       = (sh[7:4] == code_q) && !sh[3];
  wire refuse    = (sh[2:1] == 2'd2) && nvm_busy;
  wire addr_ack_nvm = (st == S_AACK) && (sp == 2'd2);

  always_comb begin
    case (sp)
      2'd2:    rd_byte = nvm[ptr];
      2'd3:    rd_byte = eep[ptr];
      default: rd_byte = ram[ptr];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        ram[i] <= '0;
        eep[i] <= '0;
        nvm[i] <= (i == int'(CODE_BYTE)) ? {4'd0, DEFAULT_CODE} : 8'd0;
      end
      scl_r <= '1; sda_r <= '1;
      st <= S_IDLE; sh <= '0; bitc <= '0; sp <= '0; ptr <= '0;
      rw <= 1'b0; is_ptr <= 1'b0; ack_m <= 1'b0; sda_oe <= 1'b0;
      copy_busy <= 1'b1; copy_idx <= '0; code_q <= DEFAULT_CODE; busy_cnt <= '0;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
      if (nvm_busy) busy_cnt <= busy_cnt - 1'b1;
      if (copy_busy) begin
        ram[copy_idx] <= nvm[copy_idx];
        copy_idx <= copy_idx + 1'b1;
        if (copy_idx == '1) begin
          copy_busy <= 1'b0;
          code_q <= nvm[CODE_BYTE][3:0];
        end
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
        code_q <= ram[CODE_BYTE][3:0];
      end else if (start_det) begin
        st <= S_ADDR; bitc <= '0; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s}; bitc <= bitc + 1'b1;
            end else if (scl_fall && bitc == 4'd8) begin
              if (hit && !refuse) begin
                st <= S_AACK; sda_oe <= 1'b1; sp <= sh[2:1]; rw <= sh[0];
              end else st <= S_IDLE;
            end
          S_AACK:
            if (scl_fall) begin
              bitc <= '0;
              if (rw) begin
                sh <= rd_byte; sda_oe <= ~rd_byte[7]; st <= S_TX;
              end else begin
                sda_oe <= 1'b0; is_ptr <= 1'b1; st <= S_RX;
              end
            end
          S_RX:
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s}; bitc <= bitc + 1'b1;
            end else if (scl_fall && bitc == 4'd8) begin
              sda_oe <= 1'b1; st <= S_RXACK;
              if (is_ptr) begin
                ptr <= sh; is_ptr <= 1'b0;
              end else begin
                ptr <= ptr + 1'b1;
                case (sp)
                  2'd2: begin nvm[ptr] <= sh; busy_cnt <= BW'(NVM_WR_CYC); end
                  2'd3: eep[ptr] <= sh;
                  default: ram[ptr] <= sh;
                endcase
              end
            end
          S_RXACK:
            if (scl_fall) begin
              sda_oe <= 1'b0; bitc <= '0; st <= S_RX;
            end
          S_TX:
            if (scl_rise) bitc <= bitc + 1'b1;
            else if (scl_fall) begin
              if (bitc == 4'd8) begin
                sda_oe <= 1'b0; st <= S_TXACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6];
              end
            end
          S_TXACK:
            if (scl_rise) begin
              ack_m <= ~sda_s; ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (ack_m) begin
                sh <= rd_byte; sda_oe <= ~rd_byte[7]; bitc <= '0; st <= S_TX;
              end else st <= S_IDLE;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

module cfg_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       stop_det,
  input logic       copy_busy,
  input logic       nvm_busy,
  input logic       addr_ack_nvm,
  input logic [3:0] code_q
);
  a_r1_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  a_r6_quiet_during_copy: assert property (@(posedge clk) disable iff (!rst_n)
    copy_busy |-> !sda_oe);
  a_r7_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_nvm |-> !nvm_busy);
  a_r8_code_moves_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> ($past(stop_det) || $past(copy_busy)));
endmodule

bind cfg_i2c_target cfg_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s), .stop_det(stop_det),
  .copy_busy(copy_busy), .nvm_busy(nvm_busy), .addr_ack_nvm(addr_ack_nvm), .code_q(code_q)
);

// File: tb/cfg_i2c_target_test.sv
module cfg_i2c_target_test;
  localparam int HB = 10;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  wire  sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   vectors = 0, errors = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  cfg_i2c_target uut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe));

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    wait_clk(2); sda_m = b; wait_clk(HB); scl_m = 1'b1; wait_clk(HB); scl_m = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    wait_clk(2); sda_m = 1'b1; wait_clk(HB); scl_m = 1'b1;
    wait_clk(HB / 2); b = sda_line; wait_clk(HB / 2); scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    wait_clk(2); sda_m = 1'b1; wait_clk(HB); scl_m = 1'b1; wait_clk(HB);
    sda_m = 1'b0; wait_clk(HB); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    wait_clk(2); sda_m = 1'b0; wait_clk(HB); scl_m = 1'b1; wait_clk(HB);
    sda_m = 1'b1; wait_clk(HB);
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(b);
    ack = !b;
  endtask

  task automatic byte_in(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); d[i] = b; end
    send_bit(!ack);
  endtask

  task automatic probe(input logic [6:0] a, output logic ack);
    i2c_start(); byte_out({a, 1'b0}, ack); i2c_stop();
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start(); byte_out({a, 1'b0}, a0); byte_out(p, a1); byte_out(d, a2); i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd1(input logic [6:0] a, input logic [7:0] p, output logic [7:0] d);
    logic a0, a1, a2;
    i2c_start(); byte_out({a, 1'b0}, a0); byte_out(p, a1);
    i2c_start(); byte_out({a, 1'b1}, a2); byte_in(d, 1'b0); i2c_stop();
    if (!(a0 & a1 & a2)) d = 8'hxx;
  endtask

  task automatic t_reset();
    logic ack; logic [7:0] d;
    wait_clk(3);
    check("R1 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    wait_clk(300);
    for (int a = 8; a < 12; a++) begin probe(7'(a), ack); check("R1 default group acks", ack, 1); end
    probe(7'h0C, ack); check("R9 above group nacks", ack, 0);
    probe(7'h07, ack); check("R9 below group nacks", ack, 0);
    rd1(7'h08, 8'hCA, d); check("R6 ram 0xCA copied from image", d, 8'h01);
    rd1(7'h0A, 8'hCA, d); check("R4 image 0xCA", d, 8'h01);
  endtask

  task automatic t_ram();
    logic ok; logic [7:0] d;
    wr1(7'h08, 8'h20, 8'h5A, ok); check("R2 ram write acked", ok, 1);
    rd1(7'h08, 8'h20, d); check("R2 ram readback", d, 8'h5A);
    rd1(7'h09, 8'h20, d); check("R3 alias reads ram", d, 8'h5A);
    wr1(7'h09, 8'h21, 8'hA6, ok);
    rd1(7'h08, 8'h21, d); check("R3 alias write visible at base", d, 8'hA6);
  endtask

  task automatic t_spaces();
    logic ok; logic [7:0] d;
    wr1(7'h0B, 8'h20, 8'hC3, ok);
    rd1(7'h0B, 8'h20, d); check("R4 data store readback", d, 8'hC3);
    rd1(7'h08, 8'h20, d); check("R4 ram untouched by store write", d, 8'h5A);
    rd1(7'h0A, 8'h20, d); check("R4 image untouched by store write", d, 8'h00);
  endtask

  task automatic t_burst();
    logic a0, a1, a2, a3, a4; logic [7:0] d0, d1, d2;
    i2c_start(); byte_out({7'h08, 1'b0}, a0); byte_out(8'hFE, a1);
    byte_out(8'h11, a2); byte_out(8'h22, a3); byte_out(8'h33, a4); i2c_stop();
    check("R5 burst write acked", a0 & a1 & a2 & a3 & a4, 1);
    i2c_start(); byte_out({7'h08, 1'b0}, a0); byte_out(8'hFE, a1);
    i2c_start(); byte_out({7'h08, 1'b1}, a2);
    byte_in(d0, 1'b1); byte_in(d1, 1'b1); byte_in(d2, 1'b0); i2c_stop();
    check("R5 burst byte at 0xFE", d0, 8'h11);
    check("R5 burst byte at 0xFF", d1, 8'h22);
    check("R5 burst wraps to 0x00", d2, 8'h33);
  endtask

  task automatic t_nvm_busy();
    logic ok, ack; logic [7:0] d;
    wr1(7'h0A, 8'h40, 8'h77, ok); check("R7 image write acked", ok, 1);
    probe(7'h0A, ack); check("R7 image nacks while busy", ack, 0);
    probe(7'h08, ack); check("R7 ram acks while image busy", ack, 1);
    wait_clk(1100);
    rd1(7'h0A, 8'h40, d); check("R7 image readback after busy", d, 8'h77);
    rd1(7'h08, 8'h40, d); check("R4 ram untouched by image write", d, 8'h00);
  endtask

  task automatic t_readdr();
    logic a0, a1, a2, a3, ack; logic [7:0] d;
    i2c_start(); byte_out({7'h08, 1'b0}, a0); byte_out(8'hCA, a1);
    byte_out(8'h02, a2); byte_out(8'h99, a3); i2c_stop();
    check("R8 transaction completes at old address", a0 & a1 & a2 & a3, 1);
    probe(7'h08, ack); check("R8 old base nacks after stop", ack, 0);
    probe(7'h10, ack); check("R8 new base acks", ack, 1);
    probe(7'h13, ack); check("R8 new base+3 acks", ack, 1);
    probe(7'h14, ack); check("R9 past new group nacks", ack, 0);
    rd1(7'h10, 8'hCB, d); check("R8 byte after code written", d, 8'h99);
  endtask

  initial begin
    t_reset();
    t_ram();
    t_spaces();
    t_burst();
    t_nvm_busy();
    t_readdr();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule